// File: doc/BRIEF.md
# Write-Leveling Delay Calibration Sequencer

This block works out, for each byte lane of a memory interface, how far the data strobe has to be delayed so that its edge meets the rising edge of the memory clock. It does not drive the delay line or the DRAM itself. Instead it controls an abstract sampling port. For each measurement it presents a lane number and a delay code in 1/256-cycle units, keeps them steady for a programmable settle time, and then raises a sample request. It waits for a valid handshake that returns the clock level seen at the strobe edge.

Each lane is handled in two passes. The coarse pass takes eight samples, one at each eighth of a cycle. The eight-bit coarse pattern is read as a ring, and the first low-to-high step in that ring gives the base eighth for the fine pass. The fine pass then steps one unit at a time inside that eighth and stops at the first high sample. The resulting delay is encoded as a half-cycle flag plus a seven-bit offset, and a result beyond 200/256 of a cycle is forced to zero. A lane whose coarse pattern has no transition is flagged as an error and is not fine-scanned.

Top module: `wl_cal_seq`

## Requirements
- R1: A write with `ctrl_we` high and `ctrl_wdata[0]` set while idle starts a run. `busy` (also `status_word[0]`) is high at the first clock after the write, and all error flags, coarse bytes and delay codes read zero. A write with bit 0 clear starts nothing.
- R2: Lane and delay code are held for at least `settle_cycles` clocks before `smp_req` rises. `smp_req`, `smp_lane` and `smp_delay` then stay unchanged until a cycle with `smp_valid` high.
- R3: Bit i of a lane's coarse byte (`coarse_res[8*lane +: 8]`) is the level sampled at delay code 32*i. A sample of 1 means the clock was high at the strobe edge.
- R4: A lane whose coarse byte is 0x00 or 0xFF gets its error flag `status_word[8+lane]` set and delay code 0x000, and it receives exactly 8 sample requests.
- R5: A lane whose coarse byte is any other value never has its error flag set.
- R6: The fine base index is the smallest i in 0..7 for which coarse bit i is 0 and bit (i+1) mod 8 is 1.
- R7: The fine pass samples delays 32*base+1, 32*base+2, and so on, and stops at the first sample of 1 or after offset 31. The raw result is the last delay that sampled 0, which is 32*base+31 when no sample returned 1.
- R8: The delay code is 9 bits. Bit 8 is a half-cycle flag worth 128/256, bit 7 is 0, and bits [6:0] hold the remaining offset (for example, 200/256 gives 0x148).
- R9: A raw result above 200/256 produces delay code 0x000. A raw result of exactly 200 is kept as 0x148.
- R10: `busy` stays high until every lane is done. `done` then pulses high for exactly one cycle while `busy` is low. Results and flags hold until the next start.
- R11: A start write while busy has no effect: the run proceeds unchanged and only one `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 8+LANES | Control write data, bit 0 = start |
| settle_cycles | input | SETTLE_W | Cycles to hold delay code before a sample request |
| status_word | output | 8+LANES | Bit 0 busy, bits [8+LANES-1:8] per-lane error flags |
| done | output | 1 | One-cycle pulse when all lanes are finished |
| coarse_res | output | 8*LANES | Coarse sample byte per lane |
| lane_delay | output | 9*LANES | Encoded delay result per lane |
| smp_req | output | 1 | Sample request |
| smp_lane | output | log2(LANES) | Lane to sample |
| smp_delay | output | FRAC_W | Strobe delay code in 1/256-cycle units |
| smp_valid | input | 1 | Sample-valid handshake |
| smp_level | input | 1 | Clock level seen at the strobe edge |

## Verification
The checks assume that the sampling side answers every request with exactly one single-cycle `smp_valid` pulse. They also assume it never raises `smp_valid` without a pending `smp_req`, and that the returned level is a function only of the lane and the delay presented. The bench models each lane as a clock waveform with a rising edge at a chosen delay and a chosen high width, or as stuck at 0 or 1. Its responder pulses valid only while a request is open, after a configurable latency, and drops it on the following cycle. Start writes are issued between clock edges as single-cycle strobes.

// File: rtl/wl_cal_pkg.sv
package wl_cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COARSE,
    ST_EVAL,
    ST_FINE,
    ST_LANE_END
  } seq_st_t;

  typedef enum logic [1:0] {
    SM_IDLE,
    SM_SETTLE,
    SM_REQ
  } smp_st_t;
endpackage

// File: rtl/wl_cal_sampler.sv
module wl_cal_sampler
  import wl_cal_pkg::*;
#(
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic [SETTLE_W-1:0] settle,
  input  logic                smp_valid,
  input  logic                smp_level,
  output logic                smp_req,
  output logic                fin,
  output logic                fin_level
);
  smp_st_t             st_q, st_d;
  logic [SETTLE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      SM_IDLE: begin
        if (launch) begin
          cnt_d = settle;
          st_d  = SM_SETTLE;
        end
      end
      SM_SETTLE: begin
        if (cnt_q == '0) st_d = SM_REQ;
        else             cnt_d = cnt_q - 1'b1;
      end
      SM_REQ: begin
        if (smp_valid) st_d = SM_IDLE;
      end
      default: st_d = SM_IDLE;
    endcase
  end

  assign smp_req   = (st_q == SM_REQ);
  assign fin       = smp_req && smp_valid;
  assign fin_level = smp_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SM_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wl_cal_ring_base.sv
module wl_cal_ring_base (
  input  logic [7:0] pat,
  output logic       valid,
  output logic [2:0] base
);
  logic [7:0] hit;

  for (genvar g = 0; g < 8; g++) begin : g_hit
    assign hit[g] = ~pat[g] & pat[(g + 1) % 8];
  end

  always_comb begin
    base = '0;
    for (int i = 7; i >= 0; i--) begin
      if (hit[i]) base = 3'(i);
    end
  end

  assign valid = |hit;
endmodule

// File: rtl/wl_cal_code_fmt.sv
module wl_cal_code_fmt #(
  parameter int FRAC_W = 8,
  parameter int LIMIT  = 200
) (
  input  logic [FRAC_W-1:0] val,
  output logic [FRAC_W:0]   code
);
  always_comb begin
    if (val > FRAC_W'(LIMIT)) code = '0;
    else                      code = {val[FRAC_W-1], 1'b0, val[FRAC_W-2:0]};
  end
endmodule

// File: rtl/wl_cal_seq.sv
module wl_cal_seq
  import wl_cal_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int FRAC_W    = 8,
  parameter int SETTLE_W  = 4,
  parameter int CLAMP_LIM = 200,
  localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int STAT_W   = 8 + LANES,
  localparam int CODE_W   = FRAC_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctrl_we,
  input  logic [STAT_W-1:0]        ctrl_wdata,
  input  logic [SETTLE_W-1:0]      settle_cycles,
  output logic [STAT_W-1:0]        status_word,
  output logic                     done,
  output logic [LANES*8-1:0]       coarse_res,
  output logic [LANES*CODE_W-1:0]  lane_delay,
  output logic                     smp_req,
  output logic [LANE_W-1:0]        smp_lane,
  output logic [FRAC_W-1:0]        smp_delay,
  input  logic                     smp_valid,
  input  logic                     smp_level
);
  localparam int FINE_W = FRAC_W - 3;

  seq_st_t                         st_q, st_d;
  logic [LANE_W-1:0]               lane_q, lane_d;
  logic [2:0]                      step_q, step_d;
  logic [FINE_W-1:0]               fstep_q, fstep_d;
  logic [FRAC_W-1:0]               dly_q, dly_d;
  logic                            launch_q, launch_d;
  logic                            done_q, done_d;
  logic [LANES-1:0][7:0]           co_q, co_d;
  logic [LANES-1:0][CODE_W-1:0]    res_q, res_d;
  logic [LANES-1:0]                err_q, err_d;

  logic              s_fin, s_level;
  logic              r_valid;
  logic [2:0]        r_base;
  logic [FRAC_W-1:0] f_val;
  logic [CODE_W-1:0] f_code;
  logic              busy;

  wl_cal_sampler #(.SETTLE_W(SETTLE_W)) u_smp (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch_q),
    .settle    (settle_cycles),
    .smp_valid (smp_valid),
    .smp_level (smp_level),
    .smp_req   (smp_req),
    .fin       (s_fin),
    .fin_level (s_level)
  );

  wl_cal_ring_base u_ring (
    .pat   (co_q[lane_q]),
    .valid (r_valid),
    .base  (r_base)
  );

  assign f_val = dly_q - {{(FRAC_W-1){1'b0}}, s_level};

  wl_cal_code_fmt #(.FRAC_W(FRAC_W), .LIMIT(CLAMP_LIM)) u_fmt (
    .val  (f_val),
    .code (f_code)
  );

  always_comb begin
    st_d     = st_q;
    lane_d   = lane_q;
    step_d   = step_q;
    fstep_d  = fstep_q;
    dly_d    = dly_q;
    co_d     = co_q;
    res_d    = res_q;
    err_d    = err_q;
    launch_d = 1'b0;
    done_d   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ctrl_we && ctrl_wdata[0]) begin
          co_d     = '0;
          res_d    = '0;
          err_d    = '0;
          lane_d   = '0;
          step_d   = '0;
          dly_d    = '0;
          launch_d = 1'b1;
          st_d     = ST_COARSE;
        end
      end
      ST_COARSE: begin
        if (s_fin) begin
          co_d[lane_q][step_q] = s_level;
          if (step_q == 3'd7) begin
            st_d = ST_EVAL;
          end else begin
            step_d   = step_q + 3'd1;
            dly_d    = {step_q + 3'd1, {FINE_W{1'b0}}};
            launch_d = 1'b1;
          end
        end
      end
      ST_EVAL: begin
        if (!r_valid) begin
          err_d[lane_q] = 1'b1;
          st_d          = ST_LANE_END;
        end else begin
          fstep_d  = FINE_W'(1);
          dly_d    = {r_base, FINE_W'(1)};
          launch_d = 1'b1;
          st_d     = ST_FINE;
        end
      end
      ST_FINE: begin
        if (s_fin) begin
          if (s_level || (&fstep_q)) begin
            res_d[lane_q] = f_code;
            st_d          = ST_LANE_END;
          end else begin
            fstep_d  = fstep_q + 1'b1;
            dly_d    = dly_q + 1'b1;
            launch_d = 1'b1;
          end
        end
      end
      ST_LANE_END: begin
        if (lane_q == LANE_W'(LANES - 1)) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          lane_d   = lane_q + 1'b1;
          step_d   = '0;
          dly_d    = '0;
          launch_d = 1'b1;
          st_d     = ST_COARSE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      lane_q   <= '0;
      step_q   <= '0;
      fstep_q  <= '0;
      dly_q    <= '0;
      launch_q <= 1'b0;
      done_q   <= 1'b0;
      co_q     <= '0;
      res_q    <= '0;
      err_q    <= '0;
    end else begin
      st_q     <= st_d;
      lane_q   <= lane_d;
      step_q   <= step_d;
      fstep_q  <= fstep_d;
      dly_q    <= dly_d;
      launch_q <= launch_d;
      done_q   <= done_d;
      co_q     <= co_d;
      res_q    <= res_d;
      err_q    <= err_d;
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign status_word = {err_q, 7'd0, busy};
  assign done        = done_q;
  assign coarse_res  = co_q;
  assign lane_delay  = res_q;
  assign smp_lane    = lane_q;
  assign smp_delay   = dly_q;
endmodule

// File: rtl/wl_cal_seq_chk.sv
module wl_cal_seq_chk #(
  parameter int LANES     = 4,
  parameter int FRAC_W    = 8,
  parameter int CLAMP_LIM = 200,
  localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CODE_W   = FRAC_W + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start_wr,
  input logic                    busy,
  input logic                    done,
  input logic [LANES-1:0]        err,
  input logic [LANES*8-1:0]      coarse_res,
  input logic [LANES*CODE_W-1:0] lane_delay,
  input logic                    smp_req,
  input logic                    smp_valid,
  input logic [LANE_W-1:0]       smp_lane,
  input logic [FRAC_W-1:0]       smp_delay
);
  localparam int OFF_LIM = CLAMP_LIM - (1 << (FRAC_W - 1));

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_wr)); // R1
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_req && !smp_valid) |=> smp_req); // R2
  AST_DELAY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_req && !smp_valid) |=> ($stable(smp_delay) && $stable(smp_lane))); // R2

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    AST_ERR_RULE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (err[l] == ((coarse_res[8*l +: 8] == 8'h00) ||
                           (coarse_res[8*l +: 8] == 8'hFF)))); // R4
    AST_CODE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!lane_delay[CODE_W*l + FRAC_W - 1] &&
                !(lane_delay[CODE_W*l + FRAC_W] &&
                  (lane_delay[CODE_W*l +: FRAC_W-1] > (FRAC_W-1)'(OFF_LIM))))); // R9
  end
endmodule

bind wl_cal_seq wl_cal_seq_chk #(
  .LANES(LANES), .FRAC_W(FRAC_W), .CLAMP_LIM(CLAMP_LIM)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_wr   (ctrl_we && ctrl_wdata[0]),
  .busy       (status_word[0]),
  .done       (done),
  .err        (status_word[8 +: LANES]),
  .coarse_res (coarse_res),
  .lane_delay (lane_delay),
  .smp_req    (smp_req),
  .smp_valid  (smp_valid),
  .smp_lane   (smp_lane),
  .smp_delay  (smp_delay)
);

// File: tb/wl_cal_seq_bench.sv
module wl_cal_seq_bench;
  localparam int LANES = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_we;
  logic [11:0] ctrl_wdata;
  logic [3:0]  settle_cycles;
  logic [11:0] status_word;
  logic        done;
  logic [31:0] coarse_res;
  logic [35:0] lane_delay;
  logic        smp_req;
  logic [1:0]  smp_lane;
  logic [7:0]  smp_delay;
  logic        smp_valid;
  logic        smp_level;

  always #5 clk = ~clk;

  wl_cal_seq u_wl_cal_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .settle_cycles(settle_cycles), .status_word(status_word), .done(done),
    .coarse_res(coarse_res), .lane_delay(lane_delay), .smp_req(smp_req),
    .smp_lane(smp_lane), .smp_delay(smp_delay), .smp_valid(smp_valid),
    .smp_level(smp_level)
  );

  int n_chk = 0;
  int n_err = 0;
  int e_m[LANES];
  int w_m[LANES];
  int md[LANES];
  int lat_cfg = 0;
  int req_cnt[LANES];
  int settle_bad = 0;
  int done_cnt = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit lvl(int l, int d);
    if (md[l] == 1) return 1'b0;
    if (md[l] == 2) return 1'b1;
    return (((d - e_m[l] + 256) % 256) < w_m[l]);
  endfunction

  // Responder for the sampling port and settle-time monitor
  initial begin
    int wait_cnt = 0;
    int stab = 0;
    logic [7:0] prev_dly = 8'h0;
    logic prev_req = 1'b0;
    smp_valid = 1'b0;
    smp_level = 1'b0;
    forever begin
      @(negedge clk);
      if (smp_delay != prev_dly) stab = 0; else stab++;
      prev_dly = smp_delay;
      if (smp_req && !prev_req && (stab < int'(settle_cycles))) settle_bad++;
      prev_req = smp_req;
      if (done) done_cnt++;
      if (smp_valid) begin
        smp_valid = 1'b0;
      end else if (smp_req) begin
        if (wait_cnt >= lat_cfg) begin
          smp_valid = 1'b1;
          smp_level = lvl(int'(smp_lane), int'(smp_delay));
          req_cnt[smp_lane]++;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  task automatic start_pulse();
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = 12'h001;
    @(negedge clk);
    ctrl_we = 1'b0; ctrl_wdata = 12'h000;
  endtask

  task automatic wait_done();
    int cyc = 0;
    while (!done && cyc < 30000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done === 1'b1, "R10", "done reached", int'(done), 1);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done one cycle", int'(done), 0);
  endtask

  task automatic run_cal(int settle, int lat);
    settle_cycles = 4'(settle);
    lat_cfg = lat;
    settle_bad = 0;
    for (int l = 0; l < LANES; l++) req_cnt[l] = 0;
    start_pulse();
    chk(status_word[0] === 1'b1, "R1", "busy after start", int'(status_word[0]), 1);
    chk(status_word[11:8] == 4'h0 && lane_delay == 36'h0, "R1", "cleared at start",
        int'(status_word[11:8]), 0);
    wait_done();
    chk(settle_bad == 0, "R2", "settle hold violations", settle_bad, 0);
  endtask

  task automatic check_lanes(string tag);
    for (int l = 0; l < LANES; l++) begin
      int cb = 0, base = 0, res = 0, nf = 0, code;
      bit er;
      for (int i = 0; i < 8; i++) if (lvl(l, 32 * i)) cb |= (1 << i);
      er = (cb == 0) || (cb == 255);
      if (!er) begin
        for (int i = 7; i >= 0; i--)
          if (((cb >> i) & 1) == 0 && ((cb >> ((i + 1) % 8)) & 1) == 1) base = i;
        for (int f = 1; f < 32; f++) begin
          nf = f;
          if (lvl(l, base * 32 + f)) begin res = base * 32 + f - 1; break; end
          res = base * 32 + f;
        end
      end
      code = (er || res > 200) ? 0 : (((res >= 128) ? 256 : 0) + res % 128);
      chk(coarse_res[8*l +: 8] == 8'(cb), "R3", $sformatf("%s coarse lane%0d", tag, l),
          int'(coarse_res[8*l +: 8]), cb);
      chk(lane_delay[9*l +: 9] == 9'(code), "R6 R7 R8 R9",
          $sformatf("%s delay lane%0d", tag, l), int'(lane_delay[9*l +: 9]), code);
      chk(status_word[8+l] == er, er ? "R4" : "R5", $sformatf("%s err lane%0d", tag, l),
          int'(status_word[8+l]), int'(er));
      chk(req_cnt[l] == 8 + nf, er ? "R4" : "R7", $sformatf("%s samples lane%0d", tag, l),
          req_cnt[l], 8 + nf);
    end
  endtask

  task automatic set_lane(int l, int e, int w, int m);
    e_m[l] = e; w_m[l] = w; md[l] = m;
  endtask

  task automatic t_reset();
    chk(status_word == 12'h0 && done == 1'b0, "R1", "reset status", int'(status_word), 0);
    chk(lane_delay == 36'h0 && coarse_res == 32'h0, "R10", "reset results",
        int'(lane_delay[8:0]), 0);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = 12'h002;
    @(negedge clk);
    ctrl_we = 1'b0; ctrl_wdata = 12'h000;
    repeat (3) @(negedge clk);
    chk(status_word[0] === 1'b0 && smp_req === 1'b0, "R1", "write w/o start bit",
        int'(status_word[0]), 0);
  endtask

  task automatic t_basic();
    set_lane(0, 33, 128, 0); set_lane(1, 64, 128, 0);
    set_lane(2, 100, 128, 0); set_lane(3, 150, 128, 0);
    run_cal(2, 0);
    check_lanes("basic");
    chk(lane_delay[35:27] == 9'h115, "R8", "half-cycle code lane3",
        int'(lane_delay[35:27]), 9'h115);
  endtask

  task automatic t_wrap();
    set_lane(0, 201, 128, 0); set_lane(1, 202, 128, 0);
    set_lane(2, 0, 160, 0);   set_lane(3, 0, 128, 0);
    run_cal(0, 3);
    check_lanes("wrap");
    chk(lane_delay[8:0] == 9'h148, "R9", "200 kept", int'(lane_delay[8:0]), 9'h148);
    chk(coarse_res[23:16] == 8'h1F, "R6", "0x1F pattern", int'(coarse_res[23:16]), 8'h1F);
  endtask

  task automatic t_err();
    set_lane(0, 0, 0, 1);   set_lane(1, 0, 0, 2);
    set_lane(2, 16, 8, 0);  set_lane(3, 250, 200, 0);
    run_cal(1, 1);
    check_lanes("err");
  endtask

  task automatic t_busy_start();
    int d0;
    set_lane(0, 40, 128, 0); set_lane(1, 90, 128, 0);
    set_lane(2, 10, 128, 0); set_lane(3, 180, 128, 0);
    settle_cycles = 4'd3; lat_cfg = 2; settle_bad = 0;
    for (int l = 0; l < LANES; l++) req_cnt[l] = 0;
    d0 = done_cnt;
    start_pulse();
    repeat (30) @(negedge clk);
    start_pulse();
    wait_done();
    repeat (50) @(negedge clk);
    chk(done_cnt - d0 == 1, "R11", "done pulses", done_cnt - d0, 1);
    chk(status_word[0] === 1'b0, "R11", "idle after run", int'(status_word[0]), 0);
    check_lanes("busy-start R11");
  endtask

  task automatic t_hold();
    logic [35:0] dl = lane_delay;
    logic [31:0] cr = coarse_res;
    logic [11:0] sw = status_word;
    repeat (40) @(negedge clk);
    chk(lane_delay == dl && coarse_res == cr, "R10", "results held",
        int'(lane_delay[8:0]), int'(dl[8:0]));
    chk(status_word == sw && done == 1'b0, "R10", "status held", int'(status_word), int'(sw));
  endtask

  initial begin
    #1_500_000;
    n_err++; n_chk++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ctrl_we = 1'b0;
    ctrl_wdata = 12'h0;
    settle_cycles = 4'd0;
    for (int l = 0; l < LANES; l++) set_lane(l, 0, 128, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_hold();
    t_wrap();
    t_err();
    t_hold();
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule